// File: doc/BRIEF.md
# Transceiver Control Register Bank

This block keeps two eight-bit control registers for a USB transceiver. A link controller reaches them over a narrow register port that carries a six-bit address, a write strobe and a byte of data. Each register sits behind three neighbouring addresses. The first replaces the writable bits. The second ORs the data into the register. The third clears every bit that is 1 in the data. A read at any of the three addresses returns the stored value.

The interface register sets the polarity of the FAULT indicator and turns interface protection on or off. It also selects the three-wire full/low-speed serial mode and holds the active-low clock-suspend control for that mode. The OTG register drives the VBUS supply, charge and discharge controls, and the line pull-down and pull-up enables. A hardware exit event clears the serial-mode bit without a bus access. Several outputs depend on more than one bit: the FAULT output follows a polarity bit, and clock power follows the serial mode, a register bit and the SUSPENDM input.

Top module: `phy_ctrl_regbank`

## Requirements
- R1: After reset the interface register holds 00h and the OTG register holds 06h. In the OTG register bit 2 (DM pull-down) and bit 1 (DP pull-down) are 1 and bit 0 (ID pull-up) is 0.
- R2: A read returns the interface register at addresses 07h, 08h and 09h, and the OTG register at 0Ah, 0Bh and 0Ch. Any other address reads 00h.
- R3: A write to 07h or 0Ah loads the data into every writable bit of that register.
- R4: A write to 08h or 0Bh ORs the data into the register.
- R5: A write to 09h or 0Ch clears each register bit whose data bit is 1 and leaves the other bits unchanged.
- R6: Bits 4, 2 and 0 of the interface register always read 0. Loads, sets and clears have no effect on them.
- R7: fault_o equals fault_i when interface bit 5 is 0, and equals the inverse of fault_i when it is 1.
- R8: A serial_exit_i pulse clears interface bit 1 (serial mode) at the next clock edge and leaves the other bits unchanged. This takes priority over a write to that bit in the same cycle.
- R9: clk_power_o is 1 whenever serial mode is off. While serial mode is on, it is 1 only when suspend_n_i is 1 and interface bit 3 is 1.
- R10: protect_en_o is the inverse of interface bit 7.
- R11: Interface bit 6 drives ind_passthru_o. OTG bits 7 down to 0 drive, in order: use_ext_ind_o, drv_ext_vbus_o, drv_vbus_o, chrg_vbus_o, dischrg_vbus_o, dm_pulldown_o, dp_pulldown_o and id_pullup_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acc_addr_i | input | 6 | Register address for reads and writes |
| acc_wr_i | input | 1 | Write strobe, sampled at the clock edge |
| acc_wdata_i | input | 8 | Write data |
| acc_rdata_o | output | 8 | Read data for acc_addr_i (combinational) |
| serial_exit_i | input | 1 | Hardware event that ends serial mode |
| suspend_n_i | input | 1 | Active-low suspend input (SUSPENDM) |
| fault_i | input | 1 | Raw FAULT indicator |
| fault_o | output | 1 | FAULT indicator after the polarity control |
| protect_en_o | output | 1 | Interface protection enable |
| ind_passthru_o | output | 1 | Indicator pass-through control |
| serial_mode_o | output | 1 | Three-wire serial mode active |
| clk_power_o | output | 1 | Clock circuitry powered |
| use_ext_ind_o | output | 1 | Use the external VBUS indicator |
| drv_ext_vbus_o | output | 1 | Drive the external VBUS supply |
| drv_vbus_o | output | 1 | Drive VBUS |
| chrg_vbus_o | output | 1 | Charge VBUS |
| dischrg_vbus_o | output | 1 | Discharge VBUS |
| dm_pulldown_o | output | 1 | DM pull-down enable |
| dp_pulldown_o | output | 1 | DP pull-down enable |
| id_pullup_o | output | 1 | ID pull-up enable |

## Verification
A wrong stored bit shows up at two places: in the read data for any alias of its register, and on the decoded pin it drives. Both appear one clock edge after the write that produced the bit. A write decoded to the wrong operation changes the read-back value at once. For example, a set that acts as a load drops bits that were already 1, and a clear that acts as a set raises bits. The tests therefore start each operation from a value with mixed ones and zeros. A lost exit-event clear leaves serial_mode_o at 1 and clk_power_o gated on the cycle after the pulse. This includes the case where a write to the same bit arrives in that cycle.

// File: rtl/phy_reg_pkg.sv
package phy_reg_pkg;

    localparam int ADDR_W = 6;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_LOAD = 2'd1,
        OP_SET  = 2'd2,
        OP_CLR  = 2'd3
    } reg_op_e;

    // Each register takes three consecutive addresses: load, set, clear.
    localparam logic [ADDR_W-1:0] IFC_BASE = 6'h07;
    localparam logic [ADDR_W-1:0] OTG_BASE = 6'h0A;

    // Interface register bit positions
    localparam int IFC_PROT_OFF  = 7;
    localparam int IFC_IND_PASS  = 6;
    localparam int IFC_IND_INV   = 5;
    localparam int IFC_CLK_KEEP  = 3;
    localparam int IFC_SER_MODE  = 1;

    // OTG register bit positions
    localparam int OTG_EXT_IND   = 7;
    localparam int OTG_DRV_EXT   = 6;
    localparam int OTG_DRV       = 5;
    localparam int OTG_CHRG      = 4;
    localparam int OTG_DISCHRG   = 3;
    localparam int OTG_DM_PD     = 2;
    localparam int OTG_DP_PD     = 1;
    localparam int OTG_ID_PU     = 0;

    localparam logic [DATA_W-1:0] IFC_RST   = 8'h00;
    localparam logic [DATA_W-1:0] IFC_WMASK = DATA_W'((1 << IFC_PROT_OFF) | (1 << IFC_IND_PASS)
                                              | (1 << IFC_IND_INV) | (1 << IFC_CLK_KEEP)
                                              | (1 << IFC_SER_MODE));
    localparam logic [DATA_W-1:0] IFC_HWCLR = DATA_W'(1 << IFC_SER_MODE);

    localparam logic [DATA_W-1:0] OTG_RST   = DATA_W'((1 << OTG_DM_PD) | (1 << OTG_DP_PD));
    localparam logic [DATA_W-1:0] OTG_WMASK = '1;
    localparam logic [DATA_W-1:0] OTG_HWCLR = '0;

    typedef struct packed {
        logic [DATA_W-1:0] val;
    } reg_state_t;

endpackage

// File: rtl/phy_reg_alias_dec.sv
module phy_reg_alias_dec
    import phy_reg_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE = 6'h00
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    output reg_op_e           op_o,
    output logic              hit_o
);

    localparam int ALIASES = 3;

    logic [ADDR_W-1:0] offset;

    always_comb begin
        offset = addr_i - BASE;
        hit_o  = (addr_i >= BASE) && (offset < ADDR_W'(ALIASES));
        op_o   = OP_NONE;
        if (wr_i && hit_o) begin
            case (offset[1:0])
                2'd0:    op_o = OP_LOAD;
                2'd1:    op_o = OP_SET;
                2'd2:    op_o = OP_CLR;
                default: op_o = OP_NONE;
            endcase
        end
    end

endmodule

// File: rtl/phy_reg_cell.sv
module phy_reg_cell
    import phy_reg_pkg::*;
#(
    parameter logic [DATA_W-1:0] RST_VAL = '0,
    parameter logic [DATA_W-1:0] WMASK   = '1,
    parameter logic [DATA_W-1:0] HWCLR   = '0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  reg_op_e           op_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              hw_clr_i,
    output logic [DATA_W-1:0] q_o
);

    reg_state_t        st_d, st_q;
    logic [DATA_W-1:0] masked;

    always_comb begin
        st_d   = st_q;
        masked = wdata_i & WMASK;
        case (op_i)
            OP_LOAD: st_d.val = (st_q.val & ~WMASK) | masked;
            OP_SET:  st_d.val = st_q.val | masked;
            OP_CLR:  st_d.val = st_q.val & ~masked;
            default: st_d.val = st_q.val;
        endcase
        // A hardware clear beats any bus operation on the same bit.
        if (hw_clr_i) begin
            st_d.val = st_d.val & ~HWCLR;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.val <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.val;

endmodule

// File: rtl/phy_ctrl_outmap.sv
module phy_ctrl_outmap
    import phy_reg_pkg::*;
(
    input  logic [DATA_W-1:0] ifc_i,
    input  logic [DATA_W-1:0] otg_i,
    input  logic              fault_i,
    input  logic              suspend_n_i,
    output logic              fault_o,
    output logic              protect_en_o,
    output logic              ind_passthru_o,
    output logic              serial_mode_o,
    output logic              clk_power_o,
    output logic              use_ext_ind_o,
    output logic              drv_ext_vbus_o,
    output logic              drv_vbus_o,
    output logic              chrg_vbus_o,
    output logic              dischrg_vbus_o,
    output logic              dm_pulldown_o,
    output logic              dp_pulldown_o,
    output logic              id_pullup_o
);

    always_comb begin
        fault_o        = fault_i ^ ifc_i[IFC_IND_INV];
        protect_en_o   = ~ifc_i[IFC_PROT_OFF];
        ind_passthru_o = ifc_i[IFC_IND_PASS];
        serial_mode_o  = ifc_i[IFC_SER_MODE];
        // The keep-clock bit counts only in serial mode with SUSPENDM high.
        clk_power_o    = ~ifc_i[IFC_SER_MODE] | (suspend_n_i & ifc_i[IFC_CLK_KEEP]);
        use_ext_ind_o  = otg_i[OTG_EXT_IND];
        drv_ext_vbus_o = otg_i[OTG_DRV_EXT];
        drv_vbus_o     = otg_i[OTG_DRV];
        chrg_vbus_o    = otg_i[OTG_CHRG];
        dischrg_vbus_o = otg_i[OTG_DISCHRG];
        dm_pulldown_o  = otg_i[OTG_DM_PD];
        dp_pulldown_o  = otg_i[OTG_DP_PD];
        id_pullup_o    = otg_i[OTG_ID_PU];
    end

endmodule

// File: rtl/phy_ctrl_regbank.sv
module phy_ctrl_regbank
    import phy_reg_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] acc_addr_i,
    input  logic              acc_wr_i,
    input  logic [DATA_W-1:0] acc_wdata_i,
    output logic [DATA_W-1:0] acc_rdata_o,
    input  logic              serial_exit_i,
    input  logic              suspend_n_i,
    input  logic              fault_i,
    output logic              fault_o,
    output logic              protect_en_o,
    output logic              ind_passthru_o,
    output logic              serial_mode_o,
    output logic              clk_power_o,
    output logic              use_ext_ind_o,
    output logic              drv_ext_vbus_o,
    output logic              drv_vbus_o,
    output logic              chrg_vbus_o,
    output logic              dischrg_vbus_o,
    output logic              dm_pulldown_o,
    output logic              dp_pulldown_o,
    output logic              id_pullup_o
);

    localparam int NUM_REGS = 2;
    localparam int IFC_IDX  = 0;
    localparam int OTG_IDX  = 1;

    localparam logic [ADDR_W-1:0] BASES   [NUM_REGS] = '{IFC_BASE, OTG_BASE};
    localparam logic [DATA_W-1:0] RSTS    [NUM_REGS] = '{IFC_RST, OTG_RST};
    localparam logic [DATA_W-1:0] WMASKS  [NUM_REGS] = '{IFC_WMASK, OTG_WMASK};
    localparam logic [DATA_W-1:0] HWCLRS  [NUM_REGS] = '{IFC_HWCLR, OTG_HWCLR};

    reg_op_e           reg_op  [NUM_REGS];
    logic              reg_hit [NUM_REGS];
    logic [DATA_W-1:0] reg_q   [NUM_REGS];
    logic              hw_clr  [NUM_REGS];
    logic [DATA_W-1:0] ifc_q, otg_q;

    assign hw_clr[IFC_IDX] = serial_exit_i;
    assign hw_clr[OTG_IDX] = 1'b0;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        phy_reg_alias_dec #(
            .BASE (BASES[g])
        ) dec_i (
            .addr_i (acc_addr_i),
            .wr_i   (acc_wr_i),
            .op_o   (reg_op[g]),
            .hit_o  (reg_hit[g])
        );

        phy_reg_cell #(
            .RST_VAL (RSTS[g]),
            .WMASK   (WMASKS[g]),
            .HWCLR   (HWCLRS[g])
        ) cell_i (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .op_i     (reg_op[g]),
            .wdata_i  (acc_wdata_i),
            .hw_clr_i (hw_clr[g]),
            .q_o      (reg_q[g])
        );
    end

    assign ifc_q = reg_q[IFC_IDX];
    assign otg_q = reg_q[OTG_IDX];

    always_comb begin
        acc_rdata_o = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (reg_hit[i]) begin
                acc_rdata_o = reg_q[i];
            end
        end
    end

    phy_ctrl_outmap outmap_i (
        .ifc_i          (ifc_q),
        .otg_i          (otg_q),
        .fault_i        (fault_i),
        .suspend_n_i    (suspend_n_i),
        .fault_o        (fault_o),
        .protect_en_o   (protect_en_o),
        .ind_passthru_o (ind_passthru_o),
        .serial_mode_o  (serial_mode_o),
        .clk_power_o    (clk_power_o),
        .use_ext_ind_o  (use_ext_ind_o),
        .drv_ext_vbus_o (drv_ext_vbus_o),
        .drv_vbus_o     (drv_vbus_o),
        .chrg_vbus_o    (chrg_vbus_o),
        .dischrg_vbus_o (dischrg_vbus_o),
        .dm_pulldown_o  (dm_pulldown_o),
        .dp_pulldown_o  (dp_pulldown_o),
        .id_pullup_o    (id_pullup_o)
    );

endmodule

// File: rtl/phy_ctrl_regbank_chk.sv
module phy_ctrl_regbank_chk
    import phy_reg_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic [ADDR_W-1:0] acc_addr_i,
    input logic              acc_wr_i,
    input logic [DATA_W-1:0] acc_wdata_i,
    input logic              serial_exit_i,
    input logic              suspend_n_i,
    input logic              fault_i,
    input logic              fault_o,
    input logic              protect_en_o,
    input logic              serial_mode_o,
    input logic              clk_power_o,
    input logic [DATA_W-1:0] ifc_q,
    input logic [DATA_W-1:0] otg_q
);

    AST_OTG_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc_wr_i && acc_addr_i == OTG_BASE) |=> (otg_q == $past(acc_wdata_i))); // R3

    AST_OTG_SET_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc_wr_i && acc_addr_i == OTG_BASE + 6'd1) |=> ((otg_q & $past(otg_q)) == $past(otg_q))); // R4

    AST_OTG_CLR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc_wr_i && acc_addr_i == OTG_BASE + 6'd2) |=> ((otg_q & $past(acc_wdata_i)) == '0)); // R5

    AST_RESERVED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ifc_q[4] | ifc_q[2] | ifc_q[0]) == 1'b0); // R6

    AST_FAULT_POLARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_o == (fault_i ^ ifc_q[IFC_IND_INV])); // R7

    AST_EXIT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        serial_exit_i |=> !serial_mode_o); // R8

    AST_CLK_OUTSIDE_SERIAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !serial_mode_o |-> clk_power_o); // R9

    AST_CLK_NEEDS_SUSPENDM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (serial_mode_o && !suspend_n_i) |-> !clk_power_o); // R9

    AST_PROTECT_MAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        protect_en_o != ifc_q[IFC_PROT_OFF]); // R10

endmodule

bind phy_ctrl_regbank phy_ctrl_regbank_chk chk_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .acc_addr_i    (acc_addr_i),
    .acc_wr_i      (acc_wr_i),
    .acc_wdata_i   (acc_wdata_i),
    .serial_exit_i (serial_exit_i),
    .suspend_n_i   (suspend_n_i),
    .fault_i       (fault_i),
    .fault_o       (fault_o),
    .protect_en_o  (protect_en_o),
    .serial_mode_o (serial_mode_o),
    .clk_power_o   (clk_power_o),
    .ifc_q         (ifc_q),
    .otg_q         (otg_q)
);

// File: tb/phy_ctrl_regbank_tb_top.sv
module phy_ctrl_regbank_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 5000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] addr = '0;
    logic       wr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       ser_exit = 1'b0;
    logic       susp_n = 1'b1;
    logic       flt_in = 1'b0;
    logic       flt_out, prot_en, passthru, ser_mode, clk_pwr;
    logic       ext_ind, drv_ext, drv, chrg, dischrg, dm_pd, dp_pd, id_pu;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    phy_ctrl_regbank dut_i (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .acc_addr_i     (addr),
        .acc_wr_i       (wr),
        .acc_wdata_i    (wdata),
        .acc_rdata_o    (rdata),
        .serial_exit_i  (ser_exit),
        .suspend_n_i    (susp_n),
        .fault_i        (flt_in),
        .fault_o        (flt_out),
        .protect_en_o   (prot_en),
        .ind_passthru_o (passthru),
        .serial_mode_o  (ser_mode),
        .clk_power_o    (clk_pwr),
        .use_ext_ind_o  (ext_ind),
        .drv_ext_vbus_o (drv_ext),
        .drv_vbus_o     (drv),
        .chrg_vbus_o    (chrg),
        .dischrg_vbus_o (dischrg),
        .dm_pulldown_o  (dm_pd),
        .dp_pulldown_o  (dp_pd),
        .id_pullup_o    (id_pu)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // Drive at the falling edge; the register updates at the rising edge in between.
    task automatic do_write(input logic [5:0] a, input logic [7:0] d, input logic ex);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1; ser_exit = ex;
        @(negedge clk);
        wr = 1'b0; ser_exit = 1'b0;
    endtask

    task automatic pulse_exit();
        @(negedge clk);
        ser_exit = 1'b1;
        @(negedge clk);
        ser_exit = 1'b0;
    endtask

    task automatic read_chk(input string tag, input logic [5:0] a, input logic [7:0] exp);
        addr = a;
        #1;
        check(tag, rdata, exp);
    endtask

    task automatic t_reset();
        read_chk("R1 ifc load alias", 6'h07, 8'h00);
        read_chk("R2 ifc set alias", 6'h08, 8'h00);
        read_chk("R2 ifc clr alias", 6'h09, 8'h00);
        read_chk("R1 otg load alias", 6'h0A, 8'h06);
        read_chk("R2 otg set alias", 6'h0B, 8'h06);
        read_chk("R2 otg clr alias", 6'h0C, 8'h06);
        read_chk("R2 unmapped 06h", 6'h06, 8'h00);
        read_chk("R2 unmapped 0Dh", 6'h0D, 8'h00);
        check("R1 pull pins", {5'b0, dm_pd, dp_pd, id_pu}, 8'h06);
        check("R10 protect after reset", {7'b0, prot_en}, 8'h01);
        check("R9 clock outside serial", {7'b0, clk_pwr}, 8'h01);
    endtask

    task automatic t_otg_ops();
        do_write(6'h0A, 8'hA5, 1'b0);
        read_chk("R3 otg load", 6'h0B, 8'hA5);
        do_write(6'h0B, 8'h42, 1'b0);
        read_chk("R4 otg set", 6'h0C, 8'hE7);
        do_write(6'h0C, 8'h81, 1'b0);
        read_chk("R5 otg clear", 6'h0A, 8'h66);
        check("R11 otg pins 66h", {ext_ind, drv_ext, drv, chrg, dischrg, dm_pd, dp_pd, id_pu}, 8'h66);
        do_write(6'h0A, 8'h19, 1'b0);
        check("R11 otg pins 19h", {ext_ind, drv_ext, drv, chrg, dischrg, dm_pd, dp_pd, id_pu}, 8'h19);
        read_chk("R2 ifc untouched by otg writes", 6'h07, 8'h00);
    endtask

    task automatic t_ifc_reserved();
        do_write(6'h07, 8'hFF, 1'b0);
        read_chk("R6 load skips reserved", 6'h07, 8'hEA);
        check("R10 protect off", {7'b0, prot_en}, 8'h00);
        check("R11 passthru pin", {7'b0, passthru}, 8'h01);
        do_write(6'h09, 8'hFF, 1'b0);
        read_chk("R5 ifc clear all", 6'h08, 8'h00);
        do_write(6'h08, 8'h15, 1'b0);
        read_chk("R6 set skips reserved", 6'h09, 8'h00);
    endtask

    task automatic t_fault();
        do_write(6'h07, 8'h00, 1'b0);
        flt_in = 1'b1; #1;
        check("R7 fault straight high", {7'b0, flt_out}, 8'h01);
        do_write(6'h08, 8'h20, 1'b0);
        check("R7 fault inverted high", {7'b0, flt_out}, 8'h00);
        flt_in = 1'b0; #1;
        check("R7 fault inverted low", {7'b0, flt_out}, 8'h01);
        do_write(6'h09, 8'h20, 1'b0);
        check("R7 fault straight low", {7'b0, flt_out}, 8'h00);
    endtask

    task automatic t_serial_exit();
        do_write(6'h07, 8'h02, 1'b0);
        check("R8 serial on", {7'b0, ser_mode}, 8'h01);
        pulse_exit();
        check("R8 exit clears mode", {7'b0, ser_mode}, 8'h00);
        do_write(6'h07, 8'h22, 1'b0);
        pulse_exit();
        read_chk("R8 exit keeps other bits", 6'h07, 8'h20);
        do_write(6'h08, 8'h02, 1'b1);
        read_chk("R8 exit beats same-cycle set", 6'h07, 8'h20);
        do_write(6'h07, 8'h0A, 1'b1);
        read_chk("R8 exit beats same-cycle load", 6'h07, 8'h08);
    endtask

    task automatic t_clock();
        susp_n = 1'b1;
        do_write(6'h07, 8'h02, 1'b0);
        check("R9 serial default unpowered", {7'b0, clk_pwr}, 8'h00);
        do_write(6'h08, 8'h08, 1'b0);
        check("R9 keep bit powers clock", {7'b0, clk_pwr}, 8'h01);
        susp_n = 1'b0; #1;
        check("R9 suspendm low ignores bit", {7'b0, clk_pwr}, 8'h00);
        do_write(6'h09, 8'h02, 1'b0);
        check("R9 outside serial powered", {7'b0, clk_pwr}, 8'h01);
        susp_n = 1'b1;
    endtask

    task automatic t_protect();
        do_write(6'h07, 8'h80, 1'b0);
        check("R10 protect disabled", {7'b0, prot_en}, 8'h00);
        do_write(6'h09, 8'h80, 1'b0);
        check("R10 protect re-enabled", {7'b0, prot_en}, 8'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_otg_ops();
        t_ifc_reserved();
        t_fault();
        t_serial_exit();
        t_clock();
        t_protect();
        finished = 1'b1;
    end

    initial begin
        for (int c = 0; c < WATCHDOG_CYCLES; c++) begin
            @(posedge clk);
            if (finished) break;
        end
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule